// File: doc/BRIEF.md
# I2C master SCL bit synchronizer

This block produces the clock line of an I2C master and keeps every bit aligned with the real state of the wire. SCL is open drain, so the block only ever pulls the line low or lets it go. After a release it waits a select-dependent monitor delay and then looks at the line through a two-stage synchronizer. When a slave is stretching the clock, or the line is rising slowly because of its load, the sample reads low. The block then holds its bit timing and raises a wait flag until the line reads high. The high phase is timed from that observed rise, so a stretched or slow edge never shortens it.

All timing advances on a tick input that runs at twice the base cycle rate. A whole number of ticks can then express the half-cycle monitor delays of 7.5, 19.5, 17.5 and 41.5 base cycles (15, 39, 35 and 83 ticks). The low and high phase lengths are counts in ticks, taken from two inputs at the start of each phase. A controller above this block asks for each bit through a request input. Start and stop conditions, SDA and byte shifting belong to that controller.

Top module: `scl_bit_sync`

## Requirements
- R1: While `master_en` is 0, `scl_drive_low` and `stretch_wait` are 0 and no bit starts, whatever `bit_req` does. After reset all three outputs are 0.
- R2: When the line is not held by another device, the time from the tick edge that releases SCL to the tick edge that drives it low again is the monitor delay plus the high count. The monitor delay in ticks is 15, 39, 35 or 83 for `clk_sel` = 0, 1, 2 or 3. A high count of 0 acts as 1.
- R3: Each low phase keeps `scl_drive_low` at 1 for exactly `lo_count` ticks, and a count of 0 acts as 1.
- R4: Let K be the first tick edge at which the pad reads high after a release. When a slave holds SCL past the monitor point, the high phase starts at tick edge K+2, because of the two synchronizer stages. The next low then starts `hi_count` ticks after that.
- R5: `stretch_wait` is 1 from the monitor point until the line is seen high, which is max(0, K+2 - (release + monitor delay)) ticks. `scl_drive_low` is never 1 during that time.
- R6: `bit_phase_low` pulses for exactly one clock cycle, in the cycle in which `scl_drive_low` rises, and at no other time.
- R7: A new low phase starts only if `bit_req` is 1 while idle or at the end of a high phase. Otherwise the line stays released.
- R8: Clearing `master_en` releases SCL and clears `stretch_wait` on the next clock edge, in any phase and whatever the state of `tick`.
- R9: Clock edges with `tick` at 0 change neither `scl_drive_low` nor `stretch_wait`, and they do not advance any phase timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timing enable at twice the base cycle rate |
| master_en | input | 1 | 1 = master mode, synchronizer active |
| clk_sel | input | 2 | Monitor delay select (0..3) |
| bit_req | input | 1 | Request to start another bit |
| scl_in | input | 1 | SCL pad level (asynchronous) |
| lo_count | input | CNT_W | Low phase length in ticks |
| hi_count | input | CNT_W | High phase length in ticks |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| bit_phase_low | output | 1 | One-cycle strobe at each low phase start |
| stretch_wait | output | 1 | Waiting for a held SCL to go high |

## Verification
A model of the open-drain bus combines the block's drive with a slave. For each bit the slave either lets the line go at once or holds it for a random number of cycles, and the tick is irregular throughout. Bits the slave does not hold test the delay-plus-count timing for every select value. Bits held past the monitor point test that the high phase is timed from the observed rise and that the wait flag covers the exact gap. Directed cases test zero counts, a frozen tick, a dropped request and disabling both in a low phase and during a stretch. Each of these tells a correct timing origin apart from one counted from the release edge.

// File: rtl/scl_bs_pkg.sv
package scl_bs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_MON,
    ST_WAIT,
    ST_HIGH
  } bs_state_t;
endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '1;
    else if (tick) shreg <= {shreg[STAGES-2:0], din};
  end

  assign dout = shreg[STAGES-1];
endmodule

// File: rtl/scl_mon_sel.sv
module scl_mon_sel #(
  parameter int MON_W   = 7,
  parameter int MON_T00 = 15,
  parameter int MON_T01 = 39,
  parameter int MON_T10 = 35,
  parameter int MON_T11 = 83
) (
  input  logic [1:0]       sel,
  output logic [MON_W-1:0] mon_ticks
);
  localparam int TABLE [4] = '{MON_T00, MON_T01, MON_T10, MON_T11};

  logic [MON_W-1:0] tbl [4];

  for (genvar gi = 0; gi < 4; gi++) begin : g_tbl
    assign tbl[gi] = MON_W'(TABLE[gi]);
  end

  assign mon_ticks = tbl[sel];
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/scl_bit_sync.sv
module scl_bit_sync
  import scl_bs_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int MON_W   = 7,
  parameter int MON_T00 = 15,
  parameter int MON_T01 = 39,
  parameter int MON_T10 = 35,
  parameter int MON_T11 = 83
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             master_en,
  input  logic [1:0]       clk_sel,
  input  logic             bit_req,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] lo_count,
  input  logic [CNT_W-1:0] hi_count,
  output logic             scl_drive_low,
  output logic             bit_phase_low,
  output logic             stretch_wait
);
  localparam int TW = (CNT_W > MON_W) ? CNT_W : MON_W;

  bs_state_t state, state_n;
  logic scl_hi;
  logic [MON_W-1:0] mon_ticks;
  logic cnt_zero, cnt_load;
  logic [TW-1:0] cnt_val;
  logic [TW-1:0] lo_ext, hi_ext, mon_ext;
  logic [TW-1:0] lo_m1, hi_m1, mon_m1;
  logic drive_n, strobe_n, wait_n;

  scl_in_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rst(rst), .tick(tick), .din(scl_in), .dout(scl_hi)
  );

  scl_mon_sel #(
    .MON_W(MON_W), .MON_T00(MON_T00), .MON_T01(MON_T01),
    .MON_T10(MON_T10), .MON_T11(MON_T11)
  ) i_mon (
    .sel(clk_sel), .mon_ticks(mon_ticks)
  );

  scl_phase_cnt #(.W(TW)) i_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(cnt_load),
    .load_val(cnt_val), .zero(cnt_zero)
  );

  // A count of zero is treated as one tick.
  assign lo_ext  = TW'(lo_count);
  assign hi_ext  = TW'(hi_count);
  assign mon_ext = TW'(mon_ticks);
  assign lo_m1   = (lo_ext == '0) ? '0 : lo_ext - 1'b1;
  assign hi_m1   = (hi_ext == '0) ? '0 : hi_ext - 1'b1;
  assign mon_m1  = (mon_ext == '0) ? '0 : mon_ext - 1'b1;

  always_comb begin
    state_n  = state;
    cnt_load = 1'b0;
    cnt_val  = '0;
    drive_n  = scl_drive_low;
    wait_n   = stretch_wait;
    strobe_n = 1'b0;
    if (!master_en) begin
      state_n = ST_IDLE;
      drive_n = 1'b0;
      wait_n  = 1'b0;
    end else if (tick) begin
      unique case (state)
        ST_IDLE: begin
          if (bit_req) begin
            state_n  = ST_LOW;
            cnt_load = 1'b1;
            cnt_val  = lo_m1;
            drive_n  = 1'b1;
            strobe_n = 1'b1;
          end
        end
        ST_LOW: begin
          if (cnt_zero) begin
            state_n  = ST_MON;
            cnt_load = 1'b1;
            cnt_val  = mon_m1;
            drive_n  = 1'b0;
          end
        end
        ST_MON: begin
          if (cnt_zero) begin
            if (scl_hi) begin
              state_n  = ST_HIGH;
              cnt_load = 1'b1;
              cnt_val  = hi_m1;
            end else begin
              state_n = ST_WAIT;
              wait_n  = 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (scl_hi) begin
            state_n  = ST_HIGH;
            cnt_load = 1'b1;
            cnt_val  = hi_m1;
            wait_n   = 1'b0;
          end
        end
        ST_HIGH: begin
          if (cnt_zero) begin
            if (bit_req) begin
              state_n  = ST_LOW;
              cnt_load = 1'b1;
              cnt_val  = lo_m1;
              drive_n  = 1'b1;
              strobe_n = 1'b1;
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      scl_drive_low <= 1'b0;
      stretch_wait  <= 1'b0;
      bit_phase_low <= 1'b0;
    end else begin
      state         <= state_n;
      scl_drive_low <= drive_n;
      stretch_wait  <= wait_n;
      bit_phase_low <= strobe_n;
    end
  end
endmodule

// File: rtl/scl_bit_sync_chk.sv
module scl_bit_sync_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic master_en,
  input logic bit_req,
  input logic scl_drive_low,
  input logic bit_phase_low,
  input logic stretch_wait
);
  p_slave_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !master_en |=> !scl_drive_low);

  p_disable_clears_r8: assert property (@(posedge clk) disable iff (rst)
    !master_en |=> !stretch_wait);

  p_wait_released_r5: assert property (@(posedge clk) disable iff (rst)
    stretch_wait |-> !scl_drive_low);

  p_strobe_at_rise_r6: assert property (@(posedge clk) disable iff (rst)
    bit_phase_low |-> (scl_drive_low && !$past(scl_drive_low)));

  p_rise_has_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_drive_low) |-> bit_phase_low);

  p_low_needs_req_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_drive_low) |-> $past(master_en && bit_req));

  p_tick_gates_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(master_en) && !$past(tick))
      |-> ($stable(scl_drive_low) && $stable(stretch_wait)));
endmodule

bind scl_bit_sync scl_bit_sync_chk i_chk (.*);

// File: tb/test_scl_bit_sync.sv
module test_scl_bit_sync;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic master_en = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic bit_req = 1'b0;
  logic scl_in;
  logic [CNT_W-1:0] lo_count = '0;
  logic [CNT_W-1:0] hi_count = '0;
  logic scl_drive_low, bit_phase_low, stretch_wait;
  logic slave_hold = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit tick_freeze = 1'b0;
  bit force_hold = 1'b0;
  int tcnt = 0;

  assign scl_in = !scl_drive_low && !slave_hold;

  scl_bit_sync #(.CNT_W(CNT_W)) i_scl_bit_sync (
    .clk(clk), .rst(rst), .tick(tick), .master_en(master_en),
    .clk_sel(clk_sel), .bit_req(bit_req), .scl_in(scl_in),
    .lo_count(lo_count), .hi_count(hi_count),
    .scl_drive_low(scl_drive_low), .bit_phase_low(bit_phase_low),
    .stretch_wait(stretch_wait)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int mon_of(input logic [1:0] s);
    case (s)
      2'd0: return 15;
      2'd1: return 39;
      2'd2: return 35;
      default: return 83;
    endcase
  endfunction

  function automatic int eff(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    if (tick) tcnt <= tcnt + 1;
    #2;
    tick <= tick_freeze ? 1'b0 : ($urandom % 4 != 0);
  end

  // Bus model and timing monitor, all in tick units
  bit prev_low = 1'b0;
  bit low_valid = 1'b0, rel_valid = 1'b0, k_valid = 1'b0;
  int t_low = 0, t_rel = 0, k_tick = 0, wait_cnt = 0, hold_left = 0;

  always @(negedge clk) begin
    bit rising, falling, pad_now;
    int exp_t, exp_w;
    if (!rst) begin
      if (!master_en) begin
        rel_valid = 1'b0;
        low_valid = 1'b0;
        slave_hold = 1'b0;
      end else begin
        rising  = scl_drive_low && !prev_low;
        falling = !scl_drive_low && prev_low;
        if (rising || bit_phase_low)
          chk(bit_phase_low == rising, "R6 strobe", int'(bit_phase_low), int'(rising));
        if (rising) begin
          if (rel_valid) begin
            chk(k_valid, "R4 line rise seen", int'(k_valid), 1);
            exp_t = imax(t_rel + mon_of(clk_sel), k_tick + 2) + eff(int'(hi_count));
            if (k_tick + 2 > t_rel + mon_of(clk_sel))
              chk(tcnt == exp_t, "R4 stretched high phase", tcnt - t_rel, exp_t - t_rel);
            else
              chk(tcnt == exp_t, "R2 monitor plus high", tcnt - t_rel, exp_t - t_rel);
            exp_w = imax(0, k_tick + 2 - (t_rel + mon_of(clk_sel)));
            chk(wait_cnt == exp_w, "R5 wait length", wait_cnt, exp_w);
          end
          t_low = tcnt;
          low_valid = 1'b1;
          rel_valid = 1'b0;
          slave_hold = 1'b1;
          if (force_hold) hold_left = 2000;
          else if ($urandom % 3 == 0) hold_left = 0;
          else hold_left = $urandom % 50;
        end
        if (falling) begin
          if (low_valid)
            chk(tcnt - t_low == eff(int'(lo_count)), "R3 low length", tcnt - t_low, eff(int'(lo_count)));
          t_rel = tcnt;
          rel_valid = 1'b1;
          k_valid = 1'b0;
          wait_cnt = 0;
          low_valid = 1'b0;
        end
        if (rel_valid && slave_hold) begin
          if (hold_left == 0) slave_hold = 1'b0;
          else hold_left--;
        end
        pad_now = !scl_drive_low && !slave_hold;
        if (rel_valid && !k_valid && tick && pad_now) begin
          k_tick = tcnt + 1;
          k_valid = 1'b1;
        end
        if (rel_valid && stretch_wait && tick) wait_cnt++;
      end
      prev_low = scl_drive_low;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_for_low(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      step();
      if (scl_drive_low) seen = 1'b1;
    end
  endtask

  initial begin
    int bad;
    bit seen;
    void'($urandom(32'h5eed_1234));
    repeat (4) step();
    rst = 1'b0;
    @(negedge clk);
    chk(!scl_drive_low && !bit_phase_low && !stretch_wait, "R1 reset state",
        int'({scl_drive_low, bit_phase_low, stretch_wait}), 0);

    // R1: slave mode never drives
    bit_req = 1'b1;
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      step();
      if (scl_drive_low || stretch_wait) bad++;
    end
    chk(bad == 0, "R1 slave mode quiet", bad, 0);
    bit_req = 1'b0;

    // Random segments across all selects, directed zero counts first
    for (int seg = 0; seg < 12; seg++) begin
      master_en = 1'b0;
      step();
      clk_sel = 2'(seg % 4);
      if (seg == 0) begin lo_count = '0; hi_count = '0; end
      else if (seg == 1) begin lo_count = 8'd40; hi_count = 8'd1; end
      else begin lo_count = CNT_W'($urandom % 25); hi_count = CNT_W'($urandom % 25); end
      step();
      master_en = 1'b1;
      bit_req = 1'b1;
      repeat (900) step();
      bit_req = 1'b0;
      repeat (700) step();
      bad = 0;
      for (int i = 0; i < 100; i++) begin
        step();
        if (scl_drive_low) bad++;
      end
      chk(bad == 0, "R7 no request stays released", bad, 0);
    end

    // R9: frozen tick holds a low phase
    master_en = 1'b0;
    step();
    clk_sel = 2'd1; lo_count = 8'd10; hi_count = 8'd5;
    step();
    master_en = 1'b1; bit_req = 1'b1;
    wait_for_low(seen);
    chk(seen, "R9 low phase reached", int'(seen), 1);
    tick_freeze = 1'b1;
    step();
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (!scl_drive_low || stretch_wait || bit_phase_low) bad++;
    end
    chk(bad == 0, "R9 frozen tick holds state", bad, 0);
    tick_freeze = 1'b0;
    repeat (300) step();

    // R8: disable in a low phase
    wait_for_low(seen);
    master_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(!scl_drive_low, "R8 disable in low phase", int'(scl_drive_low), 0);
    step();

    // R8: disable during a stretch
    force_hold = 1'b1;
    master_en = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      step();
      if (stretch_wait) seen = 1'b1;
    end
    chk(seen, "R5 stretch flagged", int'(seen), 1);
    chk(!scl_drive_low, "R5 released while waiting", int'(scl_drive_low), 0);
    master_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(!stretch_wait && !scl_drive_low, "R8 disable clears wait",
        int'({stretch_wait, scl_drive_low}), 0);
    force_hold = 1'b0;
    bit_req = 1'b0;
    repeat (5) step();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule